// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel data buses, called A and B, and passes words between them in either direction. Each direction has its own capture strobe, its own storage register, its own source selector and its own output enable. On any clock edge where a direction's strobe is high, that direction's register loads the word currently present on its source bus. This happens whatever the selectors and enables are doing. Each output port then carries either the live word from the opposite bus or the word held in that direction's register.

Each bus is presented as three vectors: an input, an output and a per-bit output enable. A surrounding tri-state pad ring or a bus model combines them into the real bus. With this split, the loop that forms when both directions pass live data is closed outside the block, where a bus keeper can settle it.

The enable for the A-to-B direction is active high. The enable for the B-to-A direction is active low. With both disabled, the two ports are pure inputs, and the registers can still be loaded.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A synchronous active-high `rst` clears both storage registers to zero. After reset, selecting stored data in both directions drives zero onto both ports.
- R2: When `cap_a2b` is 1 at a rising `clk` edge, the A-to-B register takes the value on `a_in`. Otherwise it keeps its value. Selectors and enables have no effect on this.
- R3: When `cap_b2a` is 1 at a rising `clk` edge, the B-to-A register takes the value on `b_in`. Otherwise it keeps its value. Selectors and enables have no effect on this.
- R4: While the A-to-B direction is enabled, `b_out` equals `a_in` in the same cycle when `sel_a2b`=0 (live). It equals the A-to-B register when `sel_a2b`=1 (stored).
- R5: While the B-to-A direction is enabled, `a_out` equals `b_in` in the same cycle when `sel_b2a`=0 (live). It equals the B-to-A register when `sel_b2a`=1 (stored).
- R6: `en_a2b`=1 sets every bit of `b_oe`. `en_a2b`=0 clears every bit of `b_oe` and forces `b_out` to zero.
- R7: `en_b2a_n`=0 sets every bit of `a_oe`. `en_b2a_n`=1 clears every bit of `a_oe` and forces `a_out` to zero.
- R8: With `en_a2b`=0 and `en_b2a_n`=1, neither port drives. Captures into both registers still take place.
- R9: With both directions enabled and both selectors at 1, the A-to-B register appears on `b_out` and the B-to-A register appears on `a_out` at the same time.
- R10: With both directions enabled and both selectors at 0, each output returns the opposite port's input. With no outside driver, an external keeper then holds both buses at their last value.
- R11: A register whose source bus is being driven by the block itself loads the driven value. For example, passing A live to B while both strobes are high stores the A word in both registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both registers |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Word currently on bus A |
| a_out | output | WIDTH | Word driven toward bus A |
| a_oe | output | WIDTH | Per-bit drive enable for bus A |
| b_in | input | WIDTH | Word currently on bus B |
| b_out | output | WIDTH | Word driven toward bus B |
| b_oe | output | WIDTH | Per-bit drive enable for bus B |
| cap_a2b | input | 1 | Load A-to-B register from `a_in` at the clock edge |
| cap_b2a | input | 1 | Load B-to-A register from `b_in` at the clock edge |
| sel_a2b | input | 1 | Source for `b_out`: 0 live, 1 stored |
| sel_b2a | input | 1 | Source for `a_out`: 0 live, 1 stored |
| en_a2b | input | 1 | A-to-B output enable, active high |
| en_b2a_n | input | 1 | B-to-A output enable, active low |

## Verification
On every cycle, the assertions check four things:
- each register clears under reset, loads on its strobe and otherwise holds;
- each enable vector is either all ones or all zeros;
- neither port drives when both enables are off;
- a disabled port presents zero.

Some behaviours depend on how the buses settle outside the block, so only the bench's scenarios can show them. These are the keeper-held loop in the both-live mode, the loading of a register from a bus the block itself drives, and the simultaneous exchange of stored words. The bench checks them with its own bus model and a reference register pair.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= d;
  end

  AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R1
  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
    cap |=> (q == $past(d))); // R2
  AST_NO_CAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(q)); // R3

endmodule

// File: rtl/xcvr_dir_lane.sv
module xcvr_dir_lane
  import bus_xcvr_pkg::*;
#(
  parameter int WIDTH         = 8,
  parameter bit OE_ACTIVE_LOW = 1'b0
) (
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  input  logic             sel,
  input  logic             en_raw,
  output logic [WIDTH-1:0] out_data,
  output logic [WIDTH-1:0] out_oe
);

  logic             drive;
  logic [WIDTH-1:0] picked;

  generate
    if (OE_ACTIVE_LOW) begin : g_low
      assign drive = ~en_raw;
    end else begin : g_high
      assign drive = en_raw;
    end
  endgenerate

  assign picked   = (src_sel_e'(sel) == SRC_STORED) ? stored : live;
  assign out_data = drive ? picked : '0;
  assign out_oe   = {WIDTH{drive}};

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe,
  input  logic             cap_a2b,
  input  logic             cap_b2a,
  input  logic             sel_a2b,
  input  logic             sel_b2a,
  input  logic             en_a2b,
  input  logic             en_b2a_n
);

  logic [WIDTH-1:0] reg_a2b;
  logic [WIDTH-1:0] reg_b2a;

  xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_a2b (
    .clk(clk), .rst(rst), .cap(cap_a2b), .d(a_in), .q(reg_a2b)
  );

  xcvr_store_reg #(.WIDTH(WIDTH)) u_reg_b2a (
    .clk(clk), .rst(rst), .cap(cap_b2a), .d(b_in), .q(reg_b2a)
  );

  xcvr_dir_lane #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b0)) u_lane_a2b (
    .live(a_in), .stored(reg_a2b), .sel(sel_a2b), .en_raw(en_a2b),
    .out_data(b_out), .out_oe(b_oe)
  );

  xcvr_dir_lane #(.WIDTH(WIDTH), .OE_ACTIVE_LOW(1'b1)) u_lane_b2a (
    .live(b_in), .stored(reg_b2a), .sel(sel_b2a), .en_raw(en_b2a_n),
    .out_data(a_out), .out_oe(a_oe)
  );

  AST_ISOLATION_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!en_a2b && en_b2a_n) |-> (a_oe == '0 && b_oe == '0)); // R8
  AST_B_OE_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    ($countones(b_oe) == 0 || $countones(b_oe) == WIDTH)); // R6
  AST_A_OE_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    ($countones(a_oe) == 0 || $countones(a_oe) == WIDTH)); // R7
  AST_B_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (b_oe == '0) |-> (b_out == '0)); // R6
  AST_A_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (a_oe == '0) |-> (a_out == '0)); // R7

endmodule

// File: tb/bus_xcvr_reg_bench.sv
module bus_xcvr_reg_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst;
  logic [W-1:0] bus_a, bus_b;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic         cap_a2b, cap_b2a, sel_a2b, sel_b2a, en_a2b, en_b2a_n;

  logic         c_rst, c_cap_a2b, c_cap_b2a, c_sel_a2b, c_sel_b2a, c_en_a2b, c_en_b2a_n;
  logic         ext_a_en, ext_b_en;
  logic [W-1:0] ext_a, ext_b;
  logic [W-1:0] ref_a2b, ref_b2a;
  int checks = 0;
  int errors = 0;

  bus_xcvr_reg #(.WIDTH(W)) u_bus_xcvr_reg (
    .clk(clk), .rst(rst), .a_in(bus_a), .a_out(a_out), .a_oe(a_oe),
    .b_in(bus_b), .b_out(b_out), .b_oe(b_oe),
    .cap_a2b(cap_a2b), .cap_b2a(cap_b2a), .sel_a2b(sel_a2b), .sel_b2a(sel_b2a),
    .en_a2b(en_a2b), .en_b2a_n(en_b2a_n)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    if (rst) begin
      ref_a2b = '0;
      ref_b2a = '0;
    end else begin
      if (cap_a2b) ref_a2b = bus_a;
      if (cap_b2a) ref_b2a = bus_b;
    end
    #1;
    rst = c_rst; cap_a2b = c_cap_a2b; cap_b2a = c_cap_b2a;
    sel_a2b = c_sel_a2b; sel_b2a = c_sel_b2a; en_a2b = c_en_a2b; en_b2a_n = c_en_b2a_n;
    for (int i = 0; i < 4; i++) begin
      #1;
      bus_a = (a_oe & a_out) | (~a_oe & (ext_a_en ? ext_a : bus_a));
      bus_b = (b_oe & b_out) | (~b_oe & (ext_b_en ? ext_b : bus_b));
    end
    @(negedge clk);
    if (!rst) begin
      check("R6", b_oe, en_a2b ? '1 : '0);
      check("R7", a_oe, !en_b2a_n ? '1 : '0);
      if (!en_a2b) check("R6", b_out, '0);
      else check("R4", b_out, sel_a2b ? ref_a2b : bus_a);
      if (en_b2a_n) check("R7", a_out, '0);
      else check("R5", a_out, sel_b2a ? ref_b2a : bus_b);
    end
  endtask

  task automatic ctl(input logic ea, input logic eb_n, input logic sa, input logic sb,
                     input logic ca, input logic cb);
    c_en_a2b = ea; c_en_b2a_n = eb_n; c_sel_a2b = sa; c_sel_b2a = sb;
    c_cap_a2b = ca; c_cap_b2a = cb;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cap_a2b = 0; cap_b2a = 0; sel_a2b = 0; sel_b2a = 0; en_a2b = 0; en_b2a_n = 1;
    bus_a = '0; bus_b = '0; ext_a_en = 0; ext_b_en = 0; ext_a = '0; ext_b = '0;
    ref_a2b = '0; ref_b2a = '0;
    c_rst = 1'b1; ctl(0, 1, 0, 0, 0, 0);
    cycle(); cycle();
    c_rst = 1'b0; cycle();
    check("R6", b_oe, '0); check("R7", a_oe, '0);
    // R1: stored words after reset are zero
    ctl(1, 0, 1, 1, 0, 0); cycle();
    check("R1", b_out, '0); check("R1", a_out, '0);

    // R4: live A to B, several patterns
    ctl(1, 1, 0, 0, 0, 0); ext_a_en = 1;
    ext_a = 8'h5A; cycle(); check("R4", b_out, 8'h5A);
    ext_a = 8'hFF; cycle(); check("R4", b_out, 8'hFF);
    ext_a = 8'h00; cycle(); check("R4", b_out, 8'h00);

    // R5: live B to A
    ext_a_en = 0; ext_b_en = 1; ext_b = 8'hC3;
    ctl(0, 0, 0, 0, 0, 0); cycle(); check("R5", a_out, 8'hC3);

    // R2: capture A while outputs off, then view stored word
    ext_b_en = 0; ext_a_en = 1; ext_a = 8'h3C;
    ctl(0, 1, 1, 0, 1, 0); cycle();
    ext_a = 8'h11; ctl(1, 1, 1, 0, 0, 0); cycle(); check("R2", b_out, 8'h3C);
    ext_a = 8'h22; cycle(); check("R2", b_out, 8'h3C);

    // R3: capture B, then view stored word; no-strobe hold
    ext_a_en = 0; ext_b_en = 1; ext_b = 8'h96;
    ctl(0, 1, 0, 0, 0, 1); cycle();
    ext_b = 8'h44; ctl(0, 0, 0, 1, 0, 0); cycle(); check("R3", a_out, 8'h96);
    ext_b = 8'h45; cycle(); check("R3", a_out, 8'h96);

    // R8: isolation with captures on both sides
    ext_a_en = 1; ext_a = 8'hA5; ext_b = 8'h5A;
    ctl(0, 1, 1, 1, 1, 1); cycle();
    check("R8", a_oe, '0); check("R8", b_oe, '0);
    check("R8", a_out, '0); check("R8", b_out, '0);
    // R9: exchange of stored words
    ext_a_en = 0; ext_b_en = 0; ctl(1, 0, 1, 1, 0, 0); cycle();
    check("R9", b_out, 8'hA5); check("R9", a_out, 8'h5A);
    check("R9", bus_a, 8'h5A); check("R9", bus_b, 8'hA5);

    // R11: A driven live onto B, both registers load the A word
    ctl(0, 1, 0, 0, 0, 0); cycle();
    ext_a_en = 1; ext_a = 8'h77; ctl(1, 1, 0, 0, 1, 1); cycle();
    check("R11", bus_b, 8'h77);
    ext_a_en = 0; ctl(0, 1, 0, 0, 0, 0); cycle();
    ctl(1, 0, 1, 1, 0, 0); cycle();
    check("R11", b_out, 8'h77); check("R11", a_out, 8'h77);

    // R10: both live, buses held by the keeper
    ctl(0, 1, 0, 0, 0, 0); cycle();
    ext_a_en = 1; ext_a = 8'hE1; ctl(1, 1, 0, 0, 0, 0); cycle();
    ext_a_en = 0; ctl(1, 0, 0, 0, 0, 0); cycle();
    check("R10", bus_a, 8'hE1); check("R10", bus_b, 8'hE1);
    cycle(); cycle();
    check("R10", bus_a, 8'hE1); check("R10", bus_b, 8'hE1);
    ctl(0, 1, 0, 0, 0, 0); cycle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule